// File: doc/BRIEF.md
# Serial Configuration Byte Receiver

This block listens on an asynchronous serial line and turns single received bytes into a set of seven system option flags. The line runs 8N1 at 115200 baud: eight data bits, least significant first, no parity bit in the frame and one stop bit. Each byte carries the whole flag set in its low seven bits. The top bit is an even-parity check over the byte. A byte that passes the check replaces the flags. A byte that fails is thrown away and reported on a one-cycle error strobe. The flags live in volatile registers and return to all-zero on reset, which is also the default configuration.

The block also watches the line for a long quiet period with the line held high. Once the line has been high for a set number of consecutive clock cycles, it raises a debug-mode request. That number corresponds to five seconds in the target system and is a parameter. The request stays up until the line next goes low, which is normally the start bit of a new byte. A line held low, or a line that only carries broken frames, leaves the flags as they were.

Top module: `serial_cfg_rx`

## Requirements
- R1: While reset is held, and until the first good byte arrives, all seven flag outputs, both strobes and the debug request are 0.
- R2: A frame is a low start bit, eight data bits sent LSB first, and a high stop bit, each lasting 16*BAUD_DIV clock cycles. Bits 0 to 6 of an accepted byte drive, in that order: sel_8bit_o (0 = 10-bit, 1 = 8-bit), map_jeida_o (0 = VESA, 1 = JEIDA), dbg_en_o, osd_en_o, xhair_en_o, led_off_o and fw_upd_en_o.
- R3: A byte is accepted when bit 7 equals the XOR of bits 0 to 6. On acceptance accept_o pulses high for exactly one cycle, and the new flag values appear in that same cycle. The flags never change in any cycle without that pulse.
- R4: A byte whose bit 7 differs from the XOR of bits 0 to 6 leaves every flag unchanged and pulses chk_err_o high for exactly one cycle.
- R5: A frame whose stop bit is sampled low produces neither strobe and leaves the flags unchanged. The receiver then waits for the line to return high before it looks for a new start bit.
- R6: A low pulse shorter than half a bit time is not taken as a start bit and produces no strobe.
- R7: Holding the line low for any length of time produces no strobe, leaves the flags unchanged and never raises dbg_req_o.
- R8: dbg_req_o rises after the synchronized line has been high for IDLE_CYCLES consecutive clock cycles. It then stays high while the line stays high.
- R9: Any low level on the line, including a start bit, drops dbg_req_o in the next cycle and restarts the high-time count from zero.
- R10: accept_o and chk_err_o are never high in the same cycle.
- R11: Frames sent back to back with no idle gap are each received, and the last good byte decides the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Asynchronous serial input, idle high |
| sel_8bit_o | output | 1 | Colour depth select, 1 = 8-bit |
| map_jeida_o | output | 1 | Bit mapping select, 1 = JEIDA |
| dbg_en_o | output | 1 | Debug enable flag |
| osd_en_o | output | 1 | On-screen display enable flag |
| xhair_en_o | output | 1 | Crosshair overlay enable flag |
| led_off_o | output | 1 | Rear LED strip disable flag |
| fw_upd_en_o | output | 1 | Firmware update enable flag |
| accept_o | output | 1 | One-cycle pulse when a checked byte is loaded |
| chk_err_o | output | 1 | One-cycle pulse when a byte fails its check |
| dbg_req_o | output | 1 | Debug-mode request after a long idle-high period |

## Verification
The bench builds the block with BAUD_DIV set to 2, so one bit lasts 32 clock cycles and a whole frame about 320 cycles. It sets IDLE_CYCLES to 3000, which replaces the multi-second quiet period with a few thousand cycles. With these values the bench can sample the debug request just before and just after its threshold. It can also hold the line low for longer than the idle limit, and it can still send many patterned, corrupted and back-to-back frames within a short run.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;

    // Oversampling ratio of the receiver: ticks per bit period
    localparam int unsigned OVS      = 16;
    localparam int unsigned SUB_W    = $clog2(OVS);
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned BITN_W   = $clog2(DATA_W);
    localparam int unsigned FLAG_W   = DATA_W - 1;

    // Flag set, packed so that the field order matches the byte bit order
    typedef struct packed {
        logic fw_upd_en;   // byte bit 6
        logic led_off;     // byte bit 5
        logic xhair_en;    // byte bit 4
        logic osd_en;      // byte bit 3
        logic dbg_en;      // byte bit 2
        logic map_jeida;   // byte bit 1
        logic sel_8bit;    // byte bit 0
    } cfg_flags_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        rx_state_e           st;
        logic [SUB_W-1:0]    sub;
        logic [BITN_W-1:0]   bitn;
        logic [DATA_W-1:0]   shreg;
        logic                vld;
    } rx_regs_t;

    typedef struct packed {
        cfg_flags_t flags;
        logic       acc;
        logic       err;
    } flag_regs_t;

endpackage

// File: rtl/cfgrx_tick.sv
module cfgrx_tick #(
    parameter int unsigned DIV = 54
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);

    generate
        if (DIV <= 1) begin : g_every_cycle
            assign tick_o = 1'b1;
        end else begin : g_divider
            localparam int unsigned CW = $clog2(DIV);
            logic [CW-1:0] cnt_d, cnt_q;
            logic          tick_d, tick_q;

            always_comb begin
                tick_d = 1'b0;
                if (cnt_q == CW'(DIV - 1)) begin
                    cnt_d  = '0;
                    tick_d = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b0;
                end else begin
                    cnt_q  <= cnt_d;
                    tick_q <= tick_d;
                end
            end

            assign tick_o = tick_q;
        end
    endgenerate

endmodule

// File: rtl/cfgrx_frame.sv
module cfgrx_frame
    import cfgrx_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              rx_i,
    output logic              byte_vld_o,
    output logic [DATA_W-1:0] byte_dat_o
);

    localparam logic [SUB_W-1:0]  HALF_LAST = SUB_W'(OVS / 2 - 1);
    localparam logic [SUB_W-1:0]  FULL_LAST = SUB_W'(OVS - 1);
    localparam logic [BITN_W-1:0] BIT_LAST  = BITN_W'(DATA_W - 1);

    rx_regs_t d, q;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        unique case (q.st)
            RX_IDLE: begin
                if (!rx_i) begin
                    d.st  = RX_START;
                    d.sub = '0;
                end
            end
            RX_START: begin
                if (tick_i) begin
                    if (q.sub == HALF_LAST) begin
                        d.sub  = '0;
                        d.bitn = '0;
                        d.st   = rx_i ? RX_IDLE : RX_DATA;
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick_i) begin
                    if (q.sub == FULL_LAST) begin
                        d.sub   = '0;
                        d.shreg = {rx_i, q.shreg[DATA_W-1:1]};
                        if (q.bitn == BIT_LAST) begin
                            d.st = RX_STOP;
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                        end
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick_i) begin
                    if (q.sub == FULL_LAST) begin
                        d.sub = '0;
                        if (rx_i) begin
                            d.vld = 1'b1;
                            d.st  = RX_IDLE;
                        end else begin
                            d.st = RX_HOLD;
                        end
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
            end
            RX_HOLD: begin
                if (rx_i) begin
                    d.st = RX_IDLE;
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '{st: RX_IDLE, sub: '0, bitn: '0, shreg: '0, vld: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign byte_vld_o = q.vld;
    assign byte_dat_o = q.shreg;

endmodule

// File: rtl/cfgrx_idle.sv
module cfgrx_idle #(
    parameter int unsigned IDLE_CYCLES = 500_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic req_o
);

    localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          req;
    } idle_regs_t;

    idle_regs_t d, q;

    always_comb begin
        d = q;
        if (!line_i) begin
            d.cnt = '0;
        end else if (q.cnt < LIMIT) begin
            d.cnt = q.cnt + 1'b1;
        end
        d.req = line_i && (d.cnt == LIMIT);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '{cnt: '0, req: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign req_o = q.req;

endmodule

// File: rtl/serial_cfg_rx.sv
module serial_cfg_rx
    import cfgrx_pkg::*;
#(
    parameter int unsigned BAUD_DIV    = 54,
    parameter int unsigned IDLE_CYCLES = 500_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rx_i,
    output logic sel_8bit_o,
    output logic map_jeida_o,
    output logic dbg_en_o,
    output logic osd_en_o,
    output logic xhair_en_o,
    output logic led_off_o,
    output logic fw_upd_en_o,
    output logic accept_o,
    output logic chk_err_o,
    output logic dbg_req_o
);

    // Input synchronizer, preset to the idle (high) level
    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   rx_s;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            assign sync_d = rx_i;
        end else begin : g_sync_chain
            assign sync_d = {sync_q[SYNC_STAGES-2:0], rx_i};
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rx_s = sync_q[SYNC_STAGES-1];

    logic              tick;
    logic              byte_vld;
    logic [DATA_W-1:0] byte_dat;

    cfgrx_tick #(.DIV(BAUD_DIV)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    cfgrx_frame u_frame (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .rx_i       (rx_s),
        .byte_vld_o (byte_vld),
        .byte_dat_o (byte_dat)
    );

    cfgrx_idle #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_i (rx_s),
        .req_o  (dbg_req_o)
    );

    // Flag register with even-parity check over the full byte
    flag_regs_t fr_d, fr_q;

    always_comb begin
        fr_d     = fr_q;
        fr_d.acc = 1'b0;
        fr_d.err = 1'b0;
        if (byte_vld) begin
            if (^byte_dat) begin
                fr_d.err = 1'b1;
            end else begin
                fr_d.flags = cfg_flags_t'(byte_dat[FLAG_W-1:0]);
                fr_d.acc   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fr_q <= '{flags: '0, acc: 1'b0, err: 1'b0};
        end else begin
            fr_q <= fr_d;
        end
    end

    logic [FLAG_W-1:0] cur_flags;
    assign cur_flags = fr_q.flags;

    assign sel_8bit_o  = fr_q.flags.sel_8bit;
    assign map_jeida_o = fr_q.flags.map_jeida;
    assign dbg_en_o    = fr_q.flags.dbg_en;
    assign osd_en_o    = fr_q.flags.osd_en;
    assign xhair_en_o  = fr_q.flags.xhair_en;
    assign led_off_o   = fr_q.flags.led_off;
    assign fw_upd_en_o = fr_q.flags.fw_upd_en;
    assign accept_o    = fr_q.acc;
    assign chk_err_o   = fr_q.err;

endmodule

// File: rtl/cfgrx_chk.sv
module cfgrx_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       rx_s_i,
    input logic       byte_vld_i,
    input logic [7:0] byte_dat_i,
    input logic [6:0] flags_i,
    input logic       accept_i,
    input logic       chk_err_i,
    input logic       dbg_req_i
);

    // R3: a byte with good parity is loaded in the next cycle
    a_r3_good_byte_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byte_vld_i && !(^byte_dat_i)) |=> (accept_i && flags_i == $past(byte_dat_i[6:0])));

    // R3: flags only move together with an accept pulse
    a_r3_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !accept_i |-> $stable(flags_i));

    // R4: a byte with bad parity flags an error and is dropped
    a_r4_bad_byte_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byte_vld_i && (^byte_dat_i)) |=> (chk_err_i && !accept_i && $stable(flags_i)));

    // R5: no strobe without a frame completed with a valid stop bit
    a_r5_strobe_needs_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept_i || chk_err_i) |-> $past(byte_vld_i));

    // R8: the debug request rises only after the line was high
    a_r8_req_from_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dbg_req_i) |-> $past(rx_s_i));

    // R9: a low line level drops the request in the next cycle
    a_r9_low_clears_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_s_i |=> !dbg_req_i);

    // R10: the two strobes are exclusive
    a_r10_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(accept_i && chk_err_i));

endmodule

bind serial_cfg_rx cfgrx_chk u_cfgrx_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_s_i     (rx_s),
    .byte_vld_i (byte_vld),
    .byte_dat_i (byte_dat),
    .flags_i    (cur_flags),
    .accept_i   (accept_o),
    .chk_err_i  (chk_err_o),
    .dbg_req_i  (dbg_req_o)
);

// File: tb/test_serial_cfg_rx.sv
module test_serial_cfg_rx;

    localparam int DIV  = 2;
    localparam int BT   = DIV * 16;
    localparam int IDLE = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b1;

    logic sel_8bit, map_jeida, dbg_en, osd_en, xhair_en, led_off, fw_upd_en;
    logic accept, chk_err, dbg_req;

    always #4 clk = ~clk;

    serial_cfg_rx #(
        .BAUD_DIV    (DIV),
        .IDLE_CYCLES (IDLE),
        .SYNC_STAGES (2)
    ) i_serial_cfg_rx (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .rx_i        (rx),
        .sel_8bit_o  (sel_8bit),
        .map_jeida_o (map_jeida),
        .dbg_en_o    (dbg_en),
        .osd_en_o    (osd_en),
        .xhair_en_o  (xhair_en),
        .led_off_o   (led_off),
        .fw_upd_en_o (fw_upd_en),
        .accept_o    (accept),
        .chk_err_o   (chk_err),
        .dbg_req_o   (dbg_req)
    );

    logic [6:0] flg;
    assign flg = {fw_upd_en, led_off, xhair_en, osd_en, dbg_en, map_jeida, sel_8bit};

    int checks = 0;
    int errors = 0;
    int acc_cnt = 0;
    int err_cnt = 0;
    int both_cnt = 0;

    // Strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (accept)  acc_cnt++;
            if (chk_err) err_cnt++;
            if (accept && chk_err) both_cnt++;
        end
    end

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input logic [6:0] f);
        return {^f, f};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send one frame; stop_ok=0 sends a low stop bit, then holds low for post_low cycles
    task automatic tx_frame(input logic [7:0] b, input bit stop_ok, input int post_low);
        @(negedge clk);
        rx = 1'b0;
        wait_clk(BT);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            wait_clk(BT);
        end
        rx = stop_ok;
        wait_clk(BT);
        if (!stop_ok) wait_clk(post_low);
        rx = 1'b1;
    endtask

    task automatic t_reset();
        wait_clk(3);
        chk_eq("R1", "flags in reset", flg, 0);
        chk_eq("R1", "dbg_req in reset", dbg_req, 0);
        rst_n = 1'b1;
        wait_clk(5);
        chk_eq("R1", "flags after reset", flg, 0);
        chk_eq("R1", "strobes after reset", acc_cnt + err_cnt, 0);
        chk_eq("R1", "dbg_req after reset", dbg_req, 0);
    endtask

    task automatic send_good(input logic [6:0] f, input string req);
        int a0 = acc_cnt;
        int e0 = err_cnt;
        tx_frame(mk(f), 1'b1, 0);
        wait_clk(20);
        chk_eq(req, "accept pulses", acc_cnt - a0, 1);
        chk_eq(req, "error pulses", err_cnt - e0, 0);
        chk_eq(req, "flags", flg, f);
    endtask

    task automatic t_load();
        send_good(7'b0000001, "R2");
        chk_eq("R2", "sel_8bit bit0", sel_8bit, 1);
        chk_eq("R2", "map_jeida clear", map_jeida, 0);
        send_good(7'b1000000, "R2");
        chk_eq("R2", "fw_upd_en bit6", fw_upd_en, 1);
        chk_eq("R2", "sel_8bit clear", sel_8bit, 0);
        send_good(7'b0001000, "R2");
        chk_eq("R2", "osd_en bit3", osd_en, 1);
        send_good(7'h55, "R3");
        send_good(7'h2A, "R3");
        send_good(7'h7F, "R3");
        send_good(7'h00, "R3");
        send_good(7'h36, "R3");
    endtask

    task automatic t_parity();
        int a0 = acc_cnt;
        int e0 = err_cnt;
        tx_frame(mk(7'h33) ^ 8'h80, 1'b1, 0);
        wait_clk(20);
        chk_eq("R4", "error pulses", err_cnt - e0, 1);
        chk_eq("R4", "accept pulses", acc_cnt - a0, 0);
        chk_eq("R4", "flags kept", flg, 7'h36);
        a0 = acc_cnt;
        e0 = err_cnt;
        tx_frame(mk(7'h01) ^ 8'h80, 1'b1, 0);
        wait_clk(20);
        chk_eq("R4", "error pulses second", err_cnt - e0, 1);
        chk_eq("R4", "flags kept second", flg, 7'h36);
    endtask

    task automatic t_stop();
        int a0 = acc_cnt;
        int e0 = err_cnt;
        tx_frame(mk(7'h11), 1'b0, 40);
        wait_clk(40);
        chk_eq("R5", "strobes on bad stop", (acc_cnt - a0) + (err_cnt - e0), 0);
        chk_eq("R5", "flags kept", flg, 7'h36);
        send_good(7'h11, "R5");
    endtask

    task automatic t_glitch();
        int a0 = acc_cnt;
        int e0 = err_cnt;
        @(negedge clk);
        rx = 1'b0;
        wait_clk(6);
        rx = 1'b1;
        wait_clk(400);
        chk_eq("R6", "strobes on glitch", (acc_cnt - a0) + (err_cnt - e0), 0);
        chk_eq("R6", "flags kept", flg, 7'h11);
        send_good(7'h4C, "R6");
    endtask

    task automatic t_low();
        int a0 = acc_cnt;
        int e0 = err_cnt;
        @(negedge clk);
        rx = 1'b0;
        wait_clk(IDLE + 1000);
        chk_eq("R7", "dbg_req while low", dbg_req, 0);
        chk_eq("R7", "strobes while low", (acc_cnt - a0) + (err_cnt - e0), 0);
        chk_eq("R7", "flags while low", flg, 7'h4C);
        rx = 1'b1;
        wait_clk(50);
        chk_eq("R7", "flags after release", flg, 7'h4C);
    endtask

    task automatic t_idle();
        @(negedge clk);
        rx = 1'b0;
        wait_clk(10);
        rx = 1'b1;
        wait_clk(IDLE - 20);
        chk_eq("R8", "dbg_req before limit", dbg_req, 0);
        wait_clk(60);
        chk_eq("R8", "dbg_req after limit", dbg_req, 1);
        wait_clk(500);
        chk_eq("R8", "dbg_req held", dbg_req, 1);
    endtask

    task automatic t_wake();
        int a0 = acc_cnt;
        fork
            tx_frame(mk(7'h24), 1'b1, 0);
            begin
                wait_clk(12);
                chk_eq("R9", "dbg_req at start bit", dbg_req, 0);
            end
        join
        wait_clk(100);
        chk_eq("R9", "accept after wake", acc_cnt - a0, 1);
        chk_eq("R9", "flags after wake", flg, 7'h24);
        chk_eq("R9", "dbg_req timer restarted", dbg_req, 0);
    endtask

    task automatic t_b2b();
        int a0 = acc_cnt;
        tx_frame(mk(7'h0F), 1'b1, 0);
        tx_frame(mk(7'h70), 1'b1, 0);
        tx_frame(mk(7'h5A), 1'b1, 0);
        wait_clk(20);
        chk_eq("R11", "accepts back to back", acc_cnt - a0, 3);
        chk_eq("R11", "last byte wins", flg, 7'h5A);
    endtask

    task automatic finish_run();
        chk_eq("R10", "cycles with both strobes", both_cnt, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_load();
        t_parity();
        t_stop();
        t_glitch();
        t_low();
        t_idle();
        t_wake();
        t_b2b();
        finish_run();
    end

    initial begin
        repeat (150000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule